// File: doc/BRIEF.md
# Hot-Plug Change Alert with Two GPIO Bits

This block watches a monitor hot-plug input and reports any change in the termination state on an active-low, open-drain alert output. The input goes through a synchroniser, and each synchronised sample is compared with the previous one. Any difference, in either direction, raises a sticky alert. Only a host register write clears the alert.

The block also provides two general-purpose pad bits. Each bit has a direction and an output value set through a small register port, and the host can read the raw pad level. When GPIO bit 1 is an input and routing is enabled, that pad becomes a second open-drain copy of the alert. Pads are modelled as output-enable plus data; the analog pad and the pull resistors sit outside the block.

Top module: `hpd_alert_gpio`

## Requirements
- R1: After reset the alert is released (`alert_oe`=0), neither GPIO pad is driven (`gpio_oe`=00), and the control register at address 0 reads 0.
- R2: Reset takes in the current hot-plug level without raising the alert, whether `hpd_in` is held high or low through reset and afterwards.
- R3: Any level change on `hpd_in`, rising or falling, sets the alert. A change applied just after a falling clock edge shows on `alert_oe` after the third following rising edge. A pulse that lasts only one clock also sets the alert.
- R4: Once set, the alert stays set until the host writes address 1 with data bit 0 = 1. A write to address 1 with bit 0 = 0 leaves the alert set.
- R5: If a clear write and a newly detected change fall in the same clock, the clear wins. A change detected in any later cycle sets the alert again.
- R6: The dedicated alert pad only ever drives low: whenever `alert_oe`=1, `alert_do`=0.
- R7: Address 1 reads as follows: bit 0 is the alert, bit 1 is the synchronised hot-plug level, bits 3:2 are the raw `gpio_di[1:0]`, and the other bits are 0.
- R8: Address 0 holds the control fields: bit 0 and bit 1 are the directions of GPIO 0 and GPIO 1 (1 = drive), bit 2 and bit 3 are their output values, and bit 4 routes the alert onto GPIO 1. It reads back what was written in bits 4:0, and the other bits read 0.
- R9: A GPIO bit whose direction is 1 drives its pad (`gpio_oe`=1), and `gpio_do` equals its output bit.
- R10: When GPIO 1 has direction 0 and routing is on, `gpio_oe[1]` follows the alert and `gpio_do[1]`=0. With routing off and direction 0, the pad is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hpd_in | input | 1 | Asynchronous hot-plug level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = status/clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| alert_oe | output | 1 | Alert pad drive enable (pad pulls low) |
| alert_do | output | 1 | Alert pad data, always 0 |
| gpio_di | input | 2 | GPIO pad input levels |
| gpio_oe | output | 2 | GPIO pad drive enables |
| gpio_do | output | 2 | GPIO pad output data |

## Verification
The bound assertions check four things on every cycle. A clear write is followed by a released alert. A set alert holds until a clear arrives. The alert rises only when the synchronised level has just changed. Both alert outputs drive only low. The bench scenarios cover the rest: the three-edge latency from pin to alert, the quiet start-up with the input held at either level, the single-cycle pulse, the case where a clear and a change meet in the same cycle, and the register map and pad drive under each direction and routing setting.

// File: rtl/hpd_alert_gpio.sv
module hpd_alert_gpio #(
  parameter int SYNC_STAGES = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hpd_in,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alert_oe,
  output logic          alert_do,
  input  logic [1:0]    gpio_di,
  output logic [1:0]    gpio_oe,
  output logic [1:0]    gpio_do
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW = $clog2(WARM + 1);
  localparam int CTRL_W = 5;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hpd_sync;
  logic                   hpd_prev;
  logic [CW-1:0]          warm_cnt;
  logic                   primed;
  logic                   hpd_edge;
  logic                   clr_req;
  logic                   alert_q;
  logic [CTRL_W-1:0]      ctrl_q;

  assign hpd_sync = sync_q[SYNC_STAGES-1];
  assign primed   = (warm_cnt == CW'(WARM));
  assign hpd_edge = primed && (hpd_sync != hpd_prev);
  assign clr_req  = reg_wr && reg_addr && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      hpd_prev <= 1'b0;
      warm_cnt <= '0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], hpd_in};
      hpd_prev <= hpd_sync;
      if (!primed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alert_q <= 1'b0;
    else if (clr_req)  alert_q <= 1'b0;
    else if (hpd_edge) alert_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ctrl_q <= '0;
    else if (reg_wr && !reg_addr)   ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  logic dir0, dir1, out0, out1, route;
  assign {route, out1, out0, dir1, dir0} = ctrl_q;

  assign alert_oe   = alert_q;
  assign alert_do   = 1'b0;

  assign gpio_oe[0] = dir0;
  assign gpio_do[0] = out0;
  assign gpio_oe[1] = dir1 | (route & alert_q);
  assign gpio_do[1] = dir1 ? out1 : 1'b0;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[3:0] = {gpio_di, hpd_sync, alert_q};
    else          reg_rdata[CTRL_W-1:0] = ctrl_q;
  end
endmodule

// File: rtl/hpd_alert_gpio_chk.sv
module hpd_alert_gpio_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          alert_oe,
  input logic          alert_do,
  input logic [1:0]    gpio_oe,
  input logic [1:0]    gpio_do,
  input logic          hpd_sync,
  input logic          dir1
);
  logic clr_w;
  assign clr_w = reg_wr && reg_addr && reg_wdata[0];

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !alert_oe); // R5
  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_oe && !clr_w) |=> alert_oe); // R4
  AST_RISE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_oe) |-> ($past(hpd_sync) != $past(hpd_sync, 2))); // R3
  AST_ALERT_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    alert_oe |-> !alert_do); // R6
  AST_GPIO1_ALERT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_oe[1] && !dir1) |-> (!gpio_do[1] && alert_oe)); // R10
endmodule

bind hpd_alert_gpio hpd_alert_gpio_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .alert_oe(alert_oe), .alert_do(alert_do),
  .gpio_oe(gpio_oe), .gpio_do(gpio_do), .hpd_sync(hpd_sync), .dir1(dir1)
);

// File: tb/hpd_alert_gpio_tb_top.sv
`timescale 1ns/1ps
module hpd_alert_gpio_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hpd_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alert_oe, alert_do;
  logic [1:0] gpio_di = 2'b00;
  logic [1:0] gpio_oe, gpio_do;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  hpd_alert_gpio dut_i (
    .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alert_oe(alert_oe), .alert_do(alert_do), .gpio_di(gpio_di),
    .gpio_oe(gpio_oe), .gpio_do(gpio_do)
  );

  // {hpd level, clear after settling, expected alert}
  localparam logic [2:0] VEC [8] = '{
    3'b101, 3'b101, 3'b110, 3'b001, 3'b010, 3'b000, 3'b110, 3'b001
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 1'b0; hpd_in = lvl;
    tick(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    tick(1);
    // R1: reset state
    do_reset(1'b0);
    check("R1 alert", {7'd0, alert_oe}, 8'd0);
    check("R1 gpio_oe", {6'd0, gpio_oe}, 8'd0);
    rd(1'b0, r); check("R1 ctrl", r, 8'd0);

    // vector walk: R3 R4 R7
    tick(5);
    foreach (VEC[i]) begin
      hpd_in = VEC[i][2];
      tick(4);
      if (VEC[i][1]) wr(1'b1, 8'h01);
      check("R3/R4 alert", {7'd0, alert_oe}, {7'd0, VEC[i][0]});
      rd(1'b1, r); check("R7 status", r, {6'd0, VEC[i][2], VEC[i][0]});
    end

    // R2: reset with input held high, then low
    do_reset(1'b1); tick(10);
    check("R2 high", {7'd0, alert_oe}, 8'd0);
    rd(1'b1, r); check("R2 level", r, 8'h02);
    do_reset(1'b0); tick(10);
    check("R2 low", {7'd0, alert_oe}, 8'd0);

    // R3: latency is three rising edges
    hpd_in = 1'b1;
    tick(2); check("R3 not yet", {7'd0, alert_oe}, 8'd0);
    tick(1); check("R3 latency", {7'd0, alert_oe}, 8'd1);
    // R6: alert pad drives low only
    check("R6 alert_do", {7'd0, alert_do}, 8'd0);
    // R4: write with bit0=0 does not clear
    wr(1'b1, 8'h00); tick(2);
    check("R4 no clear", {7'd0, alert_oe}, 8'd1);
    wr(1'b1, 8'h01);
    check("R4 clear", {7'd0, alert_oe}, 8'd0);

    // R3: single-cycle pulse
    hpd_in = 1'b0; tick(1); hpd_in = 1'b1; tick(6);
    check("R3 pulse", {7'd0, alert_oe}, 8'd1);
    wr(1'b1, 8'h01); tick(4);

    // R5: clear and detected change in same cycle -> clear wins
    hpd_in = 1'b0; tick(2);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
    check("R5 clear wins", {7'd0, alert_oe}, 8'd0);
    tick(4); check("R5 stays clear", {7'd0, alert_oe}, 8'd0);
    // R5: change one cycle after clear re-asserts
    hpd_in = 1'b1; tick(1);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
    tick(1); check("R5 reassert", {7'd0, alert_oe}, 8'd1);

    // R8/R9: control register and pad drive
    wr(1'b0, 8'hE5);
    rd(1'b0, r); check("R8 readback", r, 8'h05);
    check("R9 gpio0 oe/do", {4'd0, gpio_oe, gpio_do}, 8'h05);
    wr(1'b0, 8'h0A);
    check("R9 gpio1 oe/do", {4'd0, gpio_oe, gpio_do}, 8'h0A);

    // R7: raw gpio inputs
    gpio_di = 2'b10;
    rd(1'b1, r); check("R7 gpio_di", r, 8'h0B);

    // R10: routing onto GPIO 1 (alert still set)
    wr(1'b0, 8'h00);
    check("R10 no route", {6'd0, gpio_oe}, 8'd0);
    wr(1'b0, 8'h10);
    check("R10 route oe/do", {4'd0, gpio_oe, gpio_do}, 8'h08);
    wr(1'b1, 8'h01);
    check("R10 route released", {6'd0, gpio_oe}, 8'd0);
    wr(1'b0, 8'h1A);
    check("R10 dir wins", {4'd0, gpio_oe, gpio_do}, 8'h0A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule